// File: doc/BRIEF.md
# Card Interface Clock Generator

This block derives the serial clock for a memory card interface from the system clock. A 32-bit mode word, written over a simple strobe interface, holds the divide ratio, a power-save exponent, two flow-control enables and two transfer options that are only stored here. The ratio is the 8-bit divider field joined with a low-order odd bit, plus two, so both even and odd ratios from 2 to 513 are available. When power saving is requested with a non-zero exponent, the period is stretched further.

The card clock is built from one phase counter. A new period can only start at the end of a complete low phase. Stalls, resumes and ratio changes are decided only at that point, so the card never sees a shortened pulse. While a read fills the data FIFO, or a write drains it, the clock can be parked low until the FIFO recovers. A one-cycle strobe in the system domain marks each rising edge for the data shifters.

Top module: `mcard_clkgen`

## Requirements
- R1: With power save inactive, the card clock period is N = {div[7:0], odd} + 2 system cycles, where div is mode bits 7:0 and odd is mode bit 16.
- R2: Each period starts with a high phase of floor(P/2) cycles and ends with a low phase of the remaining cycles, where P is the active period.
- R3: A write stores mode bits 16 and 14:0, and every other bit of `mode_q` reads zero. The exponent is bits 10:8, the read-stall enable is bit 11, the write-stall enable is bit 12, byte mode is bit 13 and the pad select is bit 14. Reset value is zero.
- R4: While `wp_en` is high, a write strobe leaves `mode_q` unchanged.
- R5: With `ps_req` high and a non-zero exponent E, the period becomes N * (2^E + 1).
- R6: With `ps_req` high and E = 0, power save is not applied, so the period stays N, and `cfg_err` is high one cycle later. Otherwise `cfg_err` is low.
- R7: With the read-stall bit set, `xfer_rd` high and `fifo_full` high at the end of a low phase, the clock stays low and `cclk_en` goes low. The clock rises on the cycle after `fifo_full` drops.
- R8: With the write-stall bit set, `xfer_wr` high and `fifo_empty` high at the end of a low phase, the clock is held low in the same way, and it resumes when `fifo_empty` drops.
- R9: With both stall bits clear, FIFO status and direction have no effect, and the clock keeps running with `cclk_en` high.
- R10: A change in ratio or power-save state takes effect only at the next rising edge. The period already under way finishes at its old length.
- R11: `rise_stb` is high for exactly one cycle, in the same cycle that `cclk` first reads high in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word write data |
| wp_en | input | 1 | Write protect; blocks mode writes when high |
| ps_req | input | 1 | Power-save request |
| xfer_rd | input | 1 | Read transfer in progress |
| xfer_wr | input | 1 | Write transfer in progress |
| fifo_full | input | 1 | Data FIFO full |
| fifo_empty | input | 1 | Data FIFO empty |
| mode_q | output | 32 | Stored mode word |
| cclk | output | 1 | Generated card clock |
| cclk_en | output | 1 | Low while the card clock is parked by flow control |
| rise_stb | output | 1 | One-cycle strobe at each card clock rising edge |
| cfg_err | output | 1 | Power save requested with a zero exponent |

## Verification
The bench measures whole periods and high-phase lengths at the minimum ratio 2, at an odd ratio, at the maximum 513 and with power-save stretching. A design that split odd ratios the wrong way, or that mis-weighted the odd bit, would show a period or high count that is off by one. A ratio is rewritten in the middle of a period, and the bench expects that period to keep its old length. A design that reloaded at once would cut the pulse short. Stall tests hold the FIFO flags against each direction with the matching enable set and with it clear. A wrong gate would either let the clock run into a full FIFO or freeze it when no stall is enabled. Zero-exponent power save and protected writes are checked, since they must leave the clock and the mode word untouched.

// File: rtl/mcard_clk_pkg.sv
package mcard_clk_pkg;
  localparam int DIV_W   = 8;
  localparam int PWS_W   = 3;
  localparam int BASE_W  = DIV_W + 2;
  localparam int RATIO_W = BASE_W + (2 ** PWS_W) - 1 + 1;

  localparam int POS_PWS   = 8;
  localparam int POS_RSTL  = 11;
  localparam int POS_WSTL  = 12;
  localparam int POS_BYTE  = 13;
  localparam int POS_PAD   = 14;
  localparam int POS_ODD   = 16;
  localparam logic [31:0] MODE_MASK = 32'h0001_7FFF;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic [PWS_W-1:0] pws;
    logic             rd_stall_en;
    logic             wr_stall_en;
  } clk_cfg_t;

  function automatic clk_cfg_t unpack_mode(input logic [31:0] m);
    clk_cfg_t c;
    c.div         = m[DIV_W-1:0];
    c.odd         = m[POS_ODD];
    c.pws         = m[POS_PWS +: PWS_W];
    c.rd_stall_en = m[POS_RSTL];
    c.wr_stall_en = m[POS_WSTL];
    return c;
  endfunction

  function automatic logic [RATIO_W-1:0] base_ratio(input logic [DIV_W-1:0] d,
                                                    input logic o);
    logic [BASE_W-1:0] b;
    b = {1'b0, d, o} + BASE_W'(2);
    return RATIO_W'(b);
  endfunction

  function automatic logic [RATIO_W-1:0] ps_ratio(input logic [RATIO_W-1:0] n,
                                                  input logic [PWS_W-1:0] e);
    logic [RATIO_W-1:0] f;
    f = (RATIO_W'(1) << e) + RATIO_W'(1);
    return RATIO_W'(n * f);
  endfunction
endpackage

// File: rtl/mcard_mode_reg.sv
module mcard_mode_reg
  import mcard_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        protect,
  output logic [31:0] mode
);
  logic wr_ok;
  assign wr_ok = wr & ~protect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= '0;
    else if (wr_ok) mode <= wdata & MODE_MASK;
  end
endmodule

// File: rtl/mcard_ratio_sel.sv
module mcard_ratio_sel
  import mcard_clk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  clk_cfg_t           cfg,
  input  logic               ps_req,
  input  logic               xfer_rd,
  input  logic               xfer_wr,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  output logic [RATIO_W-1:0] ratio,
  output logic               stall,
  output logic               ps_bad
);
  logic               ps_ok;
  logic [RATIO_W-1:0] n_base;

  assign ps_ok  = ps_req & (cfg.pws != '0);
  assign n_base = base_ratio(cfg.div, cfg.odd);
  assign ratio  = ps_ok ? ps_ratio(n_base, cfg.pws) : n_base;
  assign stall  = (cfg.rd_stall_en & xfer_rd & fifo_full) |
                  (cfg.wr_stall_en & xfer_wr & fifo_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_bad <= 1'b0;
    else        ps_bad <= ps_req & (cfg.pws == '0);
  end
endmodule

// File: rtl/mcard_phase_gen.sv
module mcard_phase_gen
  import mcard_clk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] nxt_ratio,
  input  logic               stall,
  output logic               cclk,
  output logic               rise,
  output logic               held,
  output logic               low_end
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] cur_n;
  logic [RATIO_W-1:0] cur_hi;
  logic [RATIO_W-1:0] cnt_inc;

  assign low_end = (cnt == cur_n - RATIO_W'(1));
  assign cnt_inc = cnt + RATIO_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cur_n  <= RATIO_W'(2);
      cur_hi <= RATIO_W'(1);
      cclk   <= 1'b0;
      rise   <= 1'b0;
      held   <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (low_end) begin
        if (stall) begin
          held <= 1'b1;
        end else begin
          held   <= 1'b0;
          cnt    <= '0;
          cur_n  <= nxt_ratio;
          cur_hi <= nxt_ratio >> 1;
          cclk   <= 1'b1;
          rise   <= 1'b1;
        end
      end else begin
        cnt <= cnt_inc;
        if (cnt_inc == cur_hi) cclk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcard_clkgen.sv
module mcard_clkgen
  import mcard_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        wp_en,
  input  logic        ps_req,
  input  logic        xfer_rd,
  input  logic        xfer_wr,
  input  logic        fifo_full,
  input  logic        fifo_empty,
  output logic [31:0] mode_q,
  output logic        cclk,
  output logic        cclk_en,
  output logic        rise_stb,
  output logic        cfg_err
);
  clk_cfg_t           cfg;
  logic [RATIO_W-1:0] ratio_w;
  logic               stall_w;
  logic               held_w;
  logic               low_end_w;

  assign cfg     = unpack_mode(mode_q);
  assign cclk_en = ~held_w;

  mcard_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .protect(wp_en), .mode(mode_q)
  );

  mcard_ratio_sel u_ratio (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .ps_req(ps_req),
    .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ratio(ratio_w), .stall(stall_w), .ps_bad(cfg_err)
  );

  mcard_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .nxt_ratio(ratio_w), .stall(stall_w),
    .cclk(cclk), .rise(rise_stb), .held(held_w), .low_end(low_end_w)
  );
endmodule

// File: rtl/mcard_clkgen_chk.sv
module mcard_clkgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        wp_en,
  input logic        ps_req,
  input logic [31:0] mode_q,
  input logic        cclk,
  input logic        cclk_en,
  input logic        rise_stb,
  input logic        cfg_err,
  input logic        low_end_w
);
  logic stl_any;
  assign stl_any = mode_q[11] | mode_q[12];

  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wp_en) |=> $stable(mode_q)); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & 32'hFFFE_8000) == 32'h0); // R3
  AST_ZERO_EXP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_req && mode_q[10:8] == 3'd0 && !cfg_wr) |=> cfg_err); // R6
  AST_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_en |-> !cclk); // R7
  AST_PARK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_en) |-> $past(low_end_w)); // R10
  AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk) |-> rise_stb); // R11
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb); // R11
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!stl_any && !$past(stl_any)) |-> cclk_en); // R9
endmodule

bind mcard_clkgen mcard_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wp_en(wp_en), .ps_req(ps_req),
  .mode_q(mode_q), .cclk(cclk), .cclk_en(cclk_en), .rise_stb(rise_stb),
  .cfg_err(cfg_err), .low_end_w(low_end_w)
);

// File: tb/sim_mcard_clkgen.sv
`timescale 1ns/1ps
module sim_mcard_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        wp_en = 1'b0, ps_req = 1'b0, xfer_rd = 1'b0, xfer_wr = 1'b0;
  logic        fifo_full = 1'b0, fifo_empty = 1'b0;
  logic [31:0] mode_q;
  logic        cclk, cclk_en, rise_stb, cfg_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mcard_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .wp_en(wp_en), .ps_req(ps_req), .xfer_rd(xfer_rd), .xfer_wr(xfer_wr),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .mode_q(mode_q),
    .cclk(cclk), .cclk_en(cclk_en), .rise_stb(rise_stb), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int div, input int odd, input int ps, input int e);
    int n = div * 2 + odd + 2;
    if (ps != 0 && e != 0) n = n * ((1 << e) + 1);
    return n;
  endfunction

  task automatic write_mode(input logic [31:0] v);
    @(negedge clk); cfg_wdata = v; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!rise_stb) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    wait_rise();
    per = 0; hi = 0;
    do begin
      if (cclk) hi++;
      per++;
      @(negedge clk);
    end while (!rise_stb);
  endtask

  task automatic run_ratio(input string req, input int div, input int odd, input int ps, input int e);
    int per, hi, n;
    write_mode(32'(div) | (32'(odd) << 16) | (32'(e) << 8));
    ps_req = ps[0];
    wait_rise(); wait_rise();
    measure(per, hi);
    n = exp_ratio(div, odd, ps, e);
    check({req, " period"}, per, n);
    check("R2 high phase", hi, n / 2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R3 reset mode", mode_q, 0);
    check("R6 reset err", cfg_err, 0);
    check("R9 reset cclk_en", cclk_en, 1);
  endtask

  task automatic t_fields();
    write_mode(32'hFFFF_FFFF);
    check("R3 field mask", mode_q, 32'h0001_7FFF);
    write_mode(32'h0000_0000);
  endtask

  task automatic t_protect();
    write_mode(32'h0000_0005);
    wp_en = 1'b1;
    write_mode(32'h0000_0033);
    check("R4 protected write", mode_q, 32'h5);
    wp_en = 1'b0;
  endtask

  task automatic t_zero_exp();
    int per, hi;
    write_mode(32'h0000_0001);
    ps_req = 1'b1;
    wait_rise(); wait_rise();
    check("R6 cfg_err", cfg_err, 1);
    measure(per, hi);
    check("R6 period unchanged", per, 4);
    ps_req = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R6 cfg_err clears", cfg_err, 0);
  endtask

  task automatic t_midchange();
    int per, hi;
    write_mode(32'h0001_0003);
    wait_rise(); wait_rise();
    wait_rise();
    cfg_wdata = 32'h0000_0001; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    per = 1;
    while (!rise_stb) begin per++; @(negedge clk); end
    check("R10 old period kept", per, 9);
    measure(per, hi);
    check("R10 new period", per, 4);
  endtask

  task automatic t_stall(input string req, input int bitpos, input bit rd);
    int seen;
    write_mode(32'h0000_0001 | (32'h1 << bitpos));
    xfer_rd = rd; xfer_wr = !rd;
    wait_rise();
    if (rd) fifo_full = 1'b1; else fifo_empty = 1'b1;
    repeat (4) @(negedge clk);
    seen = 0;
    repeat (20) begin @(negedge clk); if (rise_stb) seen++; end
    check({req, " no rise while stalled"}, seen, 0);
    check({req, " cclk low"}, cclk, 0);
    check({req, " cclk_en low"}, cclk_en, 0);
    fifo_full = 1'b0; fifo_empty = 1'b0;
    @(negedge clk);
    check({req, " resumes"}, rise_stb, 1);
    check({req, " cclk high"}, cclk, 1);
    xfer_rd = 0; xfer_wr = 0;
  endtask

  task automatic t_no_proof();
    int seen;
    write_mode(32'h0000_0001);
    xfer_rd = 1; xfer_wr = 1; fifo_full = 1; fifo_empty = 1;
    seen = 0;
    repeat (24) begin @(negedge clk); if (rise_stb) seen++; end
    check("R9 free run rises", seen, 6);
    check("R9 cclk_en", cclk_en, 1);
    xfer_rd = 0; xfer_wr = 0; fifo_full = 0; fifo_empty = 0;
  endtask

  task automatic t_strobe();
    int cnt;
    write_mode(32'h0000_0002);
    wait_rise();
    check("R11 cclk high at strobe", cclk, 1);
    @(negedge clk);
    check("R11 strobe one cycle", rise_stb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_ratio("R1 min", 0, 0, 0, 0);
    run_ratio("R1 odd", 3, 1, 0, 0);
    run_ratio("R1 max", 255, 1, 0, 0);
    run_ratio("R5 powersave", 1, 0, 1, 2);
    run_ratio("R5 powersave odd", 2, 1, 1, 1);
    ps_req = 0;
    t_fields();
    t_protect();
    t_zero_exp();
    t_midchange();
    t_stall("R7", 11, 1'b1);
    t_stall("R8", 12, 1'b0);
    t_no_proof();
    t_strobe();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule